// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits between a core's data port and memory and handles load-reserved / store-conditional pairs for a single hart. It keeps one reservation: a valid flag and a word address. A load-reserved request is always forwarded to memory. It records a reservation only when the target region supports exclusive access and the bus returns no error. A store-conditional is forwarded as a write only when a live reservation covers the same word. Otherwise the write is suppressed. Every store-conditional clears the reservation, whatever its outcome.

Each accepted request gets a registered reply one cycle later, carried on two flags. Success is error low with exclusive-okay high. Exclusive failure is both flags low. A bus error is error high with exclusive-okay low. For a store-conditional, the reply data holds the destination-register value: 0 on success and 1 otherwise. Loads return the memory data. A write from another master (the snoop port) to the reserved word drops the reservation. A return-from-trap pulse has no effect on it. A per-region enable vector, indexed by the top address bits, selects which regions allow exclusive access.

Top module: `resv_monitor`

## Requirements
- R1: After reset there is no reservation and `rsp_valid` is low; a store-conditional issued first fails with reply data 1 and no memory request.
- R2: A load-reserved to an enabled region that gets no bus error replies error 0, exclusive-okay 1 and records its word address.
- R3: A store-conditional whose word matches a live reservation drives `mem_req` and `mem_we` in the same cycle and replies error 0, exclusive-okay 1, data 0.
- R4: A store-conditional with no reservation, or to a different word, drives no memory request, ignores `mem_err`, and replies error 0, exclusive-okay 0, data 1.
- R5: Every store-conditional leaves no reservation, whether it passed, failed or met a bus error.
- R6: A load-reserved to a region whose bit in `region_excl_en` (indexed by `req_addr[31:30]`) is 0 is still forwarded and returns its data. It replies exclusive-okay 0 and leaves no reservation, so a later store-conditional fails.
- R7: A bus error on a forwarded request replies error 1, exclusive-okay 0. A load-reserved with an error leaves no reservation. A store-conditional with an error replies data 1.
- R8: A new load-reserved replaces any earlier reservation.
- R9: A snoop write to the reserved word clears the reservation, and a snoop to another word does not. Within one cycle the snoop takes effect before the request: a load-reserved in that cycle still reserves, and a store-conditional in that cycle fails.
- R10: `trap_ret` has no effect on the reservation.
- R11: A plain load (`req_op`=00) or store (01) is forwarded with `mem_we`=`req_op[0]`. It replies exclusive-okay 0 and error equal to `mem_err`, and leaves the reservation unchanged.
- R12: Matching is by word (`req_addr[31:2]`); byte-offset bits are ignored.
- R13: The reply is valid exactly one cycle after each request, and all reply fields are 0 in a cycle after no request. Operation codes: 10 load-reserved, 11 store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| region_excl_en | input | 2**REGION_BITS | Per-region exclusive-access enable |
| trap_ret | input | 1 | Return-from-trap event |
| snoop_we | input | 1 | Write by another master |
| snoop_addr | input | ADDR_W | Address of that write |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| mem_err | input | 1 | Memory bus error, same cycle |
| rsp_valid | output | 1 | Reply valid |
| rsp_err | output | 1 | Reply bus-error flag |
| rsp_exokay | output | 1 | Reply exclusive-okay flag |
| rsp_rdata | output | DATA_W | Load data or store-conditional result |

## Verification
The reservation cannot be seen at the ports. It shows up only through the outcome of a store-conditional, and that store-conditional destroys it. Each probe therefore takes a sequence of its own: a fresh load-reserved, then the disturbance under test (snoop, trap return, plain access, failed load-reserved, bus error), then one store-conditional whose reply shows the state. Same-cycle races between snoop and request are driven in one step. A long mixed phase afterwards uses few addresses, so matches happen often, and compares against a behavioural model each cycle.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LR    = 2'b10,
        OP_SC    = 2'b11
    } bus_op_e;

    typedef struct packed {
        logic err;
        logic exokay;
    } excl_rsp_t;

    // Two-flag reply encoding: error wins, exclusive-okay only on a granted exclusive
    function automatic excl_rsp_t encode_rsp(input logic excl, input logic granted,
                                             input logic bus_err);
        excl_rsp_t r;
        r.err    = bus_err;
        r.exokay = excl & granted & ~bus_err;
        return r;
    endfunction

    function automatic logic is_excl(input bus_op_e op);
        return op == OP_LR || op == OP_SC;
    endfunction

endpackage

// File: rtl/resv_region_check.sv
module resv_region_check #(
    parameter int REGION_BITS = 2
) (
    input  logic [REGION_BITS-1:0]      region_idx,
    input  logic [(1<<REGION_BITS)-1:0] region_en,
    output logic                        region_ok
);
    localparam int NREG = 1 << REGION_BITS;

    logic [NREG-1:0] hit;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign hit[i] = (region_idx == REGION_BITS'(i)) & region_en[i];
    end

    assign region_ok = |hit;
endmodule

// File: rtl/resv_store.sv
module resv_store #(
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snoop_we,
    input  logic [WORD_W-1:0] snoop_word,
    input  logic              lr_fire,
    input  logic              lr_ok,
    input  logic [WORD_W-1:0] lr_word,
    input  logic              sc_fire,
    output logic              resv_valid,
    output logic [WORD_W-1:0] resv_word,
    output logic              resv_live
);
    logic snoop_hit;

    assign snoop_hit = snoop_we & resv_valid & (snoop_word == resv_word);
    // Reservation as seen by a request in this cycle: the snoop is ordered first
    assign resv_live = resv_valid & ~snoop_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_valid <= 1'b0;
            resv_word  <= '0;
        end else if (lr_fire) begin
            resv_valid <= lr_ok;
            if (lr_ok) resv_word <= lr_word;
        end else if (sc_fire || snoop_hit) begin
            resv_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/resv_resp.sv
module resv_resp import resv_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  bus_op_e           op,
    input  logic              sc_pass,
    input  logic              region_ok,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_exokay,
    output logic [DATA_W-1:0] rsp_rdata
);
    excl_rsp_t         code_n;
    logic              granted;
    logic [DATA_W-1:0] rdata_n;

    always_comb begin
        granted = (op == OP_LR) ? region_ok : sc_pass;
        code_n  = encode_rsp(is_excl(op), granted, bus_err);
        unique case (op)
            OP_LOAD, OP_LR: rdata_n = mem_rdata;
            OP_SC:          rdata_n = {{(DATA_W-1){1'b0}}, ~(sc_pass & ~bus_err)};
            default:        rdata_n = '0;
        endcase
        if (!req_valid) begin
            code_n  = '0;
            rdata_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_exokay <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_err    <= code_n.err;
            rsp_exokay <= code_n.exokay;
            rsp_rdata  <= rdata_n;
        end
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor import resv_pkg::*; #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int REGION_BITS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic [(1<<REGION_BITS)-1:0] region_excl_en,
    input  logic                        trap_ret,
    input  logic                        snoop_we,
    input  logic [ADDR_W-1:0]           snoop_addr,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic                        mem_err,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic                        rsp_exokay,
    output logic [DATA_W-1:0]           rsp_rdata
);
    localparam int OFS_BITS = $clog2(DATA_W / 8);
    localparam int WORD_W   = ADDR_W - OFS_BITS;

    bus_op_e           op;
    logic [WORD_W-1:0] req_word;
    logic [WORD_W-1:0] snoop_word;
    logic              region_ok;
    logic              resv_valid;
    logic [WORD_W-1:0] resv_word;
    logic              resv_live;
    logic              sc_pass;
    logic              bus_err;
    logic              lr_fire;
    logic              sc_fire;
    logic              lr_ok;
    logic [OFS_BITS:0] snoop_unused;

    assign op         = bus_op_e'(req_op);
    assign req_word   = req_addr[ADDR_W-1:OFS_BITS];
    assign snoop_word = snoop_addr[ADDR_W-1:OFS_BITS];
    // A trap return deliberately leaves the reservation alone
    assign snoop_unused = {trap_ret, snoop_addr[OFS_BITS-1:0]};

    resv_region_check #(.REGION_BITS(REGION_BITS)) u_region (
        .region_idx (req_addr[ADDR_W-1 -: REGION_BITS]),
        .region_en  (region_excl_en),
        .region_ok  (region_ok)
    );

    assign lr_fire = req_valid & (op == OP_LR);
    assign sc_fire = req_valid & (op == OP_SC);
    assign sc_pass = sc_fire & resv_live & (resv_word == req_word);

    assign mem_req   = req_valid & ((op != OP_SC) | sc_pass);
    assign mem_we    = req_op[0];
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;
    assign bus_err   = mem_req & mem_err;
    assign lr_ok     = region_ok & ~bus_err;

    resv_store #(.WORD_W(WORD_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .snoop_we   (snoop_we),
        .snoop_word (snoop_word),
        .lr_fire    (lr_fire),
        .lr_ok      (lr_ok),
        .lr_word    (req_word),
        .sc_fire    (sc_fire),
        .resv_valid (resv_valid),
        .resv_word  (resv_word),
        .resv_live  (resv_live)
    );

    resv_resp #(.DATA_W(DATA_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .op         (op),
        .sc_pass    (sc_pass),
        .region_ok  (region_ok),
        .bus_err    (bus_err),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_exokay (rsp_exokay),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              trap_ret,
    input logic              snoop_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic              region_ok,
    input logic              resv_valid,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              rsp_exokay,
    input logic [DATA_W-1:0] rsp_rdata
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !resv_valid));

    // R13
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R13
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err && !rsp_exokay));

    // R7
    excl_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_err && rsp_exokay));

    // R5
    sc_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11) |=> !resv_valid);

    // R4
    sc_no_resv_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11 && !resv_valid) |-> !mem_req);

    // R3
    sc_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11 && mem_req) |-> mem_we);

    // R3
    sc_result_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11) |=>
            (rsp_rdata[DATA_W-1:1] == '0 && rsp_rdata[0] == !rsp_exokay));

    // R6
    lr_region_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10 && !region_ok) |=> (!resv_valid && !rsp_exokay));

    // R10
    trap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_ret && !req_valid && !snoop_we) |=> $stable(resv_valid));
endmodule

bind resv_monitor resv_monitor_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
    localparam int CLK_NS = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  region_excl_en = 4'b1011;
    logic        trap_ret = 1'b0;
    logic        snoop_we = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_err = 1'b0;
    logic        rsp_valid, rsp_err, rsp_exokay;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    // Behavioural reservation model
    bit          m_valid = 0;
    logic [29:0] m_word = '0;
    bit          e_valid = 0, e_err = 0, e_exok = 0;
    logic [31:0] e_rdata = '0;
    string       e_tag = "R1";

    always #(CLK_NS / 2.0) clk = ~clk;

    assign mem_rdata = mem_addr ^ 32'h5A5A_0F0F;

    resv_monitor dut (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_rsp();
        chk(e_tag, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
        chk(e_tag, "rsp_err", 32'(rsp_err), 32'(e_err));
        chk(e_tag, "rsp_exokay", 32'(rsp_exokay), 32'(e_exok));
        chk(e_tag, "rsp_rdata", rsp_rdata, e_rdata);
    endtask

    // Called at a falling edge; checks the previous reply, applies one request
    task automatic step(input string tag, input bit v, input logic [1:0] op,
                        input logic [31:0] a, input bit err = 0, input bit sw = 0,
                        input logic [31:0] sa = 0, input bit tr = 0);
        bit live, pass, ereq, beff, rok;
        check_rsp();
        req_valid = v; req_op = op; req_addr = a; req_wdata = ~a;
        mem_err = err; snoop_we = sw; snoop_addr = sa; trap_ret = tr;
        #1;
        live = m_valid && !(sw && sa[31:2] == m_word);
        rok  = region_excl_en[a[31:30]];
        pass = v && op == 2'b11 && live && a[31:2] == m_word;
        ereq = v && (op != 2'b11 || pass);
        beff = ereq && err;
        chk(tag, "mem_req", 32'(mem_req), 32'(ereq));
        if (ereq) begin
            chk(tag, "mem_we", 32'(mem_we), 32'(op[0]));
            chk(tag, "mem_addr", mem_addr, a);
        end
        e_tag   = tag;
        e_valid = v;
        e_err   = beff;
        e_exok  = v && ((op == 2'b10 && rok && !beff) || (pass && !beff));
        if (!v)               e_rdata = '0;
        else if (op == 2'b11) e_rdata = {31'b0, !(pass && !beff)};
        else if (op[0] == 0)  e_rdata = a ^ 32'h5A5A_0F0F;
        else                  e_rdata = '0;
        m_valid = live;
        if (v && op == 2'b10) begin
            m_valid = rok && !beff;
            if (m_valid) m_word = a[31:2];
        end else if (v && op == 2'b11) begin
            m_valid = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input bit tr = 0);
        step(tag, 0, 2'b00, 0, 0, 0, 0, tr);
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b10:   return "R2";
            2'b11:   return "R3";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: first SC after reset fails
        step("R1", 1, 2'b11, 32'h100);
        idle("R1");
        // R2 / R3: basic pair, R5: second SC fails
        step("R2", 1, 2'b10, 32'h100);
        step("R3", 1, 2'b11, 32'h100);
        step("R5", 1, 2'b11, 32'h100);
        // R12: byte offset ignored
        step("R12", 1, 2'b10, 32'h200);
        step("R12", 1, 2'b11, 32'h203);
        // R4: other word fails, error ignored; then R5 cleared after failing SC
        step("R4", 1, 2'b10, 32'h300);
        step("R4", 1, 2'b11, 32'h304, 1);
        step("R5", 1, 2'b11, 32'h300);
        // R6: disabled region
        step("R6", 1, 2'b10, 32'h8000_0040);
        step("R6", 1, 2'b11, 32'h8000_0040);
        step("R6", 1, 2'b10, 32'h400);
        step("R6", 1, 2'b10, 32'h8000_0040);
        step("R6", 1, 2'b11, 32'h400);
        // R7: bus errors
        step("R7", 1, 2'b10, 32'h500, 1);
        step("R7", 1, 2'b11, 32'h500);
        step("R7", 1, 2'b10, 32'h600);
        step("R7", 1, 2'b11, 32'h600, 1);
        step("R5", 1, 2'b11, 32'h600);
        // R8: overwrite
        step("R8", 1, 2'b10, 32'h700);
        step("R8", 1, 2'b10, 32'h704);
        step("R8", 1, 2'b11, 32'h700);
        step("R8", 1, 2'b10, 32'h700);
        step("R8", 1, 2'b10, 32'h704);
        step("R8", 1, 2'b11, 32'h704);
        // R9: snoop
        step("R9", 1, 2'b10, 32'h800);
        step("R9", 0, 2'b00, 0, 0, 1, 32'h804);
        step("R9", 1, 2'b11, 32'h800);
        step("R9", 1, 2'b10, 32'h800);
        step("R9", 0, 2'b00, 0, 0, 1, 32'h802);
        step("R9", 1, 2'b11, 32'h800);
        step("R9", 1, 2'b10, 32'h900, 0, 1, 32'h900);
        step("R9", 1, 2'b11, 32'h900);
        step("R9", 1, 2'b10, 32'h900);
        step("R9", 1, 2'b11, 32'h900, 0, 1, 32'h901);
        // R10: trap return keeps reservation
        step("R10", 1, 2'b10, 32'hA00);
        idle("R10", 1);
        idle("R10", 1);
        step("R10", 1, 2'b11, 32'hA00, 0, 0, 0, 1);
        // R11: plain accesses leave reservation
        step("R11", 1, 2'b10, 32'hB00);
        step("R11", 1, 2'b01, 32'hB00);
        step("R11", 1, 2'b00, 32'hB04);
        step("R11", 1, 2'b01, 32'hB08, 1);
        step("R11", 1, 2'b11, 32'hB00);
        // R13: idle reply
        idle("R13");
        idle("R13");
        // Mixed phase
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  op;
            logic [31:0] a, sa;
            op = 2'($urandom_range(0, 3));
            a  = {2'($urandom_range(0, 3)), 26'b0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            sa = {2'($urandom_range(0, 3)), 26'b0, 2'($urandom_range(0, 3)), 2'b00};
            step(op_tag(op), ($urandom_range(0, 7) != 0), op, a,
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 5) == 0), sa,
                 ($urandom_range(0, 7) == 0));
        end
        idle("R13");
        check_rsp();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule